// File: doc/BRIEF.md
# Cell Transmit Queue with Head-of-Line Flush

This block holds complete 53-byte cells on their way to as many as eight PHY ports, which share one master-side transmit interface. Each cell arrives one byte per cycle and carries a destination port number. The oldest stored cell is the head. The block drives the head's port number on the address lines and waits for that port's cell-available answer. When the answer comes, the block streams out the head cell. Every cell behind the head waits until the head has gone.

A stalled PHY would otherwise hold up traffic for every other port. To prevent this, an optional flush timer drops a head cell that has waited longer than a 16-bit programmable limit and records its port in a per-port discard status vector. A summary flag is raised whenever any status bit is set, and a masked interrupt follows the flag. Software can also disable individual ports. Cells queued for a disabled port are removed without sending them and without recording anything. Software reads the status vector and pulses a read strobe, which clears the vector.

Top module: `cell_txq_flush`

## Requirements
- R1: A new cell is accepted (`in_ready` high at its first byte) only while fewer cells are stored than `cfg_depth`. Values 1 to 9 are honoured, and any value above 9 acts as 9. Once a cell's first byte is taken, `in_ready` stays high until its 53rd byte.
- R2: A cell starts on the transmit side (`tx_sop` with `tx_valid`) only in the cycle after one in which `tx_addr_valid` and `tx_clav` were both high.
- R3: Sent cells leave in arrival order with their bytes unchanged. While the head waits (`tx_addr_valid` high), no cell is sent.
- R4: With `cfg_flush_en` low, a waiting head cell is never dropped, however long it waits.
- R5: With `cfg_flush_en` high, a head cell whose port never answers shows `tx_addr_valid` for exactly `cfg_thresh`+1 cycles and is then dropped. This holds for every threshold from 0 to 65535. The next head starts its own wait at a count of zero.
- R6: A timeout drop sets bit N of `port_status`, where N is the dropped cell's port number. `discard_flag` is high whenever any bit of `port_status` is set. `irq` equals `discard_flag` AND `cfg_irq_mask`.
- R7: A one-cycle `stat_rd` pulse clears all of `port_status` and `discard_flag` on the next edge. A timeout drop on that same edge still leaves its own bit set.
- R8: Cells whose port has its bit set in `cfg_port_dis` are dropped at the head without being sent. These drops set no status bit and raise no interrupt, and cells for other ports are still sent in order.
- R9: A timeout drop does not disable the port. Later cells for the same port are sent normally once the port answers.
- R10: A cell is sent as 53 consecutive `tx_valid` cycles. `tx_sop` is high on the first of them only, and `tx_addr` holds the cell's port throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A cell byte is offered |
| in_ready | output | 1 | The offered byte is taken on this edge |
| in_byte | input | 8 | Cell byte |
| in_port | input | 3 | Destination port, sampled with the first byte of a cell |
| cfg_depth | input | 4 | Number of cells the queue may hold (1 to 9) |
| cfg_flush_en | input | 1 | Enables the head-of-line timeout |
| cfg_thresh | input | 16 | Timeout limit in wait cycles |
| cfg_port_dis | input | 8 | Per-port disable mask |
| cfg_irq_mask | input | 1 | Interrupt enable for the discard flag |
| tx_addr | output | 3 | Port of the head cell |
| tx_addr_valid | output | 1 | Head cell is waiting for its port's cell-available |
| tx_clav | input | 1 | Cell-available answer of the addressed port |
| tx_valid | output | 1 | A cell byte is on `tx_byte` |
| tx_sop | output | 1 | First byte of a cell |
| tx_byte | output | 8 | Outgoing cell byte |
| stat_rd | input | 1 | Status read strobe, clears the status vector |
| port_status | output | 8 | Per-port timeout discard record |
| discard_flag | output | 1 | Any status bit set |
| irq | output | 1 | Masked discard interrupt |

## Verification
The hardest case to reach is a status read that lands on the same edge as a timeout drop, because the drop edge depends on when the head cell reached the front and on the threshold. The stimulus blocks one port and loads a small threshold. It counts the address cycles of that head at the falling edge, raises the read strobe exactly on the cycle where the count reaches the threshold plus one, and then expects only that port's bit to survive. A second case that needs setup is a queue filled to its full configured depth behind a silent port. The stimulus reaches it by pushing cells while all cell-available answers are held low.

// File: rtl/cell_txq_pkg.sv
package cell_txq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // What happens to the head cell on the coming edge
  typedef enum logic [1:0] {
    HD_NONE     = 2'd0,
    HD_SENT     = 2'd1,
    HD_TIMEOUT  = 2'd2,
    HD_DISABLED = 2'd3
  } head_evt_e;
endpackage

// File: rtl/cell_txq_store.sv
module cell_txq_store #(
  parameter int SLOTS = 9,
  parameter int BEATS = 53,
  parameter int PW    = 3,
  parameter int DW    = 8,
  localparam int CW   = $clog2(SLOTS + 1),
  localparam int SW   = $clog2(SLOTS),
  localparam int BW   = $clog2(BEATS),
  localparam int AW   = $clog2(SLOTS * BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_byte,
  input  logic [PW-1:0] in_port,
  input  logic [CW-1:0] cfg_depth,
  input  logic          pop,
  input  logic [BW-1:0] rd_beat,
  output logic          head_valid,
  output logic [PW-1:0] head_port,
  output logic [DW-1:0] rd_byte
);
  logic [DW-1:0] mem  [SLOTS*BEATS];
  logic [PW-1:0] pmem [SLOTS];

  logic [SW-1:0] wr_slot_q, wr_slot_d, rd_slot_q, rd_slot_d;
  logic [CW-1:0] count_q, count_d, eff_depth;
  logic [BW-1:0] wr_beat_q, wr_beat_d;
  logic [AW-1:0] wr_addr, rd_addr;
  logic          acc, commit;

  function automatic logic [SW-1:0] slot_inc(input logic [SW-1:0] s);
    return (s == SW'(SLOTS - 1)) ? '0 : s + SW'(1);
  endfunction

  assign eff_depth = (cfg_depth > CW'(SLOTS)) ? CW'(SLOTS) : cfg_depth;
  assign in_ready  = (wr_beat_q != '0) || (count_q < eff_depth);
  assign acc       = in_valid && in_ready;
  assign commit    = acc && (wr_beat_q == BW'(BEATS - 1));
  assign wr_addr   = AW'(wr_slot_q) * AW'(BEATS) + AW'(wr_beat_q);
  assign rd_addr   = AW'(rd_slot_q) * AW'(BEATS) + AW'(rd_beat);

  assign head_valid = (count_q != '0);
  assign head_port  = pmem[rd_slot_q];
  assign rd_byte    = mem[rd_addr];

  always_comb begin
    wr_beat_d = wr_beat_q;
    wr_slot_d = wr_slot_q;
    rd_slot_d = rd_slot_q;
    if (acc) wr_beat_d = commit ? '0 : wr_beat_q + BW'(1);
    if (commit) wr_slot_d = slot_inc(wr_slot_q);
    if (pop) rd_slot_d = slot_inc(rd_slot_q);
    count_d = count_q + CW'(commit) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_slot_q <= '0;
      rd_slot_q <= '0;
      count_q   <= '0;
      wr_beat_q <= '0;
    end else begin
      wr_slot_q <= wr_slot_d;
      rd_slot_q <= rd_slot_d;
      count_q   <= count_d;
      wr_beat_q <= wr_beat_d;
    end
  end

  // Payload storage carries no reset
  always_ff @(posedge clk) begin
    if (acc) mem[wr_addr] <= in_byte;
    if (acc && (wr_beat_q == '0)) pmem[wr_slot_q] <= in_port;
  end
endmodule

// File: rtl/cell_txq_wait.sv
module cell_txq_wait #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          waiting,
  input  logic          clav,
  input  logic          flush_en,
  input  logic [TW-1:0] thresh,
  output logic          timeout
);
  logic [TW-1:0] cnt_q, cnt_d;

  assign timeout = waiting && !clav && flush_en && (cnt_q == thresh);

  always_comb begin
    if (waiting && !clav && !timeout) cnt_d = cnt_q + TW'(1);
    else                              cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cell_txq_status.sv
module cell_txq_status #(
  parameter int NPORT = 8,
  localparam int PW   = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [PW-1:0]    set_port,
  input  logic             rd,
  input  logic             irq_mask,
  output logic [NPORT-1:0] status,
  output logic             flag,
  output logic             irq
);
  logic [NPORT-1:0] st_q, st_d;

  for (genvar p = 0; p < NPORT; p++) begin : g_bit
    logic hit;
    assign hit = set_en && (set_port == PW'(p));
    always_comb st_d[p] = (st_q[p] && !rd) || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status = st_q;
  assign flag   = |st_q;
  assign irq    = flag && irq_mask;
endmodule

// File: rtl/cell_txq_flush.sv
module cell_txq_flush
  import cell_txq_pkg::*;
#(
  parameter int NPORT     = 8,
  parameter int MAX_CELLS = 9,
  parameter int BEATS     = 53,
  parameter int DW        = 8,
  parameter int TW        = 16,
  localparam int PW       = $clog2(NPORT),
  localparam int CW       = $clog2(MAX_CELLS + 1),
  localparam int BW       = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_byte,
  input  logic [PW-1:0]    in_port,
  input  logic [CW-1:0]    cfg_depth,
  input  logic             cfg_flush_en,
  input  logic [TW-1:0]    cfg_thresh,
  input  logic [NPORT-1:0] cfg_port_dis,
  input  logic             cfg_irq_mask,
  output logic [PW-1:0]    tx_addr,
  output logic             tx_addr_valid,
  input  logic             tx_clav,
  output logic             tx_valid,
  output logic             tx_sop,
  output logic [DW-1:0]    tx_byte,
  input  logic             stat_rd,
  output logic [NPORT-1:0] port_status,
  output logic             discard_flag,
  output logic             irq
);
  logic          head_valid, head_dis, start, last, pop, timeout;
  logic [PW-1:0] head_port;
  logic          sending_q, sending_d;
  logic [BW-1:0] beat_q, beat_d;
  head_evt_e     evt;

  cell_txq_store #(.SLOTS(MAX_CELLS), .BEATS(BEATS), .PW(PW), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte), .in_port(in_port),
    .cfg_depth(cfg_depth), .pop(pop), .rd_beat(beat_q),
    .head_valid(head_valid), .head_port(head_port), .rd_byte(tx_byte)
  );

  cell_txq_wait #(.TW(TW)) wait_i (
    .clk(clk), .rst_n(rst_n), .waiting(tx_addr_valid), .clav(tx_clav),
    .flush_en(cfg_flush_en), .thresh(cfg_thresh), .timeout(timeout)
  );

  cell_txq_status #(.NPORT(NPORT)) status_i (
    .clk(clk), .rst_n(rst_n), .set_en(evt == HD_TIMEOUT), .set_port(head_port),
    .rd(stat_rd), .irq_mask(cfg_irq_mask),
    .status(port_status), .flag(discard_flag), .irq(irq)
  );

  assign head_dis      = cfg_port_dis[head_port];
  assign tx_addr       = head_port;
  assign tx_addr_valid = head_valid && !sending_q && !head_dis;
  assign start         = tx_addr_valid && tx_clav;
  assign last          = sending_q && (beat_q == BW'(BEATS - 1));
  assign tx_valid      = sending_q;
  assign tx_sop        = sending_q && (beat_q == '0);

  always_comb begin
    if (last)                                  evt = HD_SENT;
    else if (head_valid && !sending_q && head_dis) evt = HD_DISABLED;
    else if (timeout)                          evt = HD_TIMEOUT;
    else                                       evt = HD_NONE;
  end
  assign pop = (evt != HD_NONE);

  always_comb begin
    sending_d = sending_q;
    if (start)     sending_d = 1'b1;
    else if (last) sending_d = 1'b0;
    beat_d = '0;
    if (sending_q && !last) beat_d = beat_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending_q <= 1'b0;
      beat_q    <= '0;
    end else begin
      sending_q <= sending_d;
      beat_q    <= beat_d;
    end
  end
endmodule

// File: rtl/cell_txq_flush_chk.sv
module cell_txq_flush_chk #(
  parameter int NPORT = 8,
  parameter int BEATS = 53,
  parameter int PW    = 3,
  localparam int BW   = $clog2(BEATS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_flush_en,
  input logic [NPORT-1:0] cfg_port_dis,
  input logic [PW-1:0]    tx_addr,
  input logic             tx_addr_valid,
  input logic             tx_clav,
  input logic             tx_valid,
  input logic             tx_sop,
  input logic             stat_rd,
  input logic [NPORT-1:0] port_status,
  input logic             irq
);
  logic [BW-1:0] bt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bt_q <= '0;
    else if (tx_valid) bt_q <= (bt_q == BW'(BEATS - 1)) ? '0 : bt_q + BW'(1);
  end

  a_r2_clav_before_sop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop |-> $past(tx_addr_valid && tx_clav));

  a_r3_hold_behind_head: assert property (@(posedge clk) disable iff (!rst_n)
    tx_addr_valid |-> !tx_valid);

  a_r4_no_drop_unflushed: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_addr_valid && !tx_clav && !cfg_flush_en) |=>
      ((tx_addr_valid && tx_addr == $past(tx_addr)) || cfg_port_dis[$past(tx_addr)]));

  for (genvar p = 0; p < NPORT; p++) begin : g_cause
    a_r5_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_status[p]) |->
        $past(tx_addr_valid && !tx_clav && cfg_flush_en && tx_addr == PW'(p)));
  end

  a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (port_status != '0));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tx_addr_valid) |=> (port_status == '0));

  a_r10_burst_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_q != '0) |-> (tx_valid && !tx_sop));

  a_r10_sop_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop |-> (bt_q == '0));
endmodule

bind cell_txq_flush cell_txq_flush_chk #(.NPORT(NPORT), .BEATS(BEATS), .PW(PW)) chk_i (.*);

// File: tb/cell_txq_flush_tb_top.sv
module cell_txq_flush_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk, rst_n, in_valid, in_ready;
  logic [7:0] in_byte;
  logic [2:0] in_port;
  logic [3:0] cfg_depth;
  logic       cfg_flush_en, cfg_irq_mask, stat_rd;
  logic [15:0] cfg_thresh;
  logic [7:0] cfg_port_dis, phy_ok;
  logic [2:0] tx_addr;
  logic       tx_addr_valid, tx_clav, tx_valid, tx_sop, discard_flag, irq;
  logic [7:0] tx_byte, port_status;

  int n_cmp = 0, n_bad = 0;
  int exp_n = 0, rx_n = 0, rx_beat = 0;
  logic [2:0] exp_port [256];
  logic [7:0] exp_base [256];
  logic [2:0] rx_port;
  bit rx_err, rnd_done;

  cell_txq_flush dut_i (.*);

  assign tx_clav = phy_ok[tx_addr];

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Receive monitor: one check per completed cell (R3, R10)
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (rx_beat == 0) begin
        rx_err  = !tx_sop;
        rx_port = tx_addr;
      end else if (tx_sop || tx_addr != rx_port) rx_err = 1'b1;
      if (tx_byte != 8'(exp_base[rx_n] + rx_beat)) rx_err = 1'b1;
      if (rx_beat == 52) begin
        chk(!rx_err && rx_n < exp_n && rx_port == exp_port[rx_n],
            "R3 R10 cell order/content/port", int'(rx_port), int'(exp_port[rx_n]));
        rx_n++;
        rx_beat = 0;
      end else rx_beat++;
    end
  end

  task automatic push(input logic [2:0] p, input logic [7:0] b, input bit delivered);
    if (delivered) begin
      exp_port[exp_n] = p;
      exp_base[exp_n] = b;
      exp_n++;
    end
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_byte  = 8'(b + i);
      in_port  = p;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while ((rx_n != exp_n || tx_valid || tx_addr_valid) && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic count_wait(input logic [2:0] p, output int n);
    n = 0;
    while (tx_addr_valid && tx_addr == p && n < 70000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_read();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired rx=%0d expected=%0d", rx_n, exp_n);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_port = '0;
    cfg_depth = 4'd9; cfg_flush_en = 1'b0; cfg_thresh = '0; cfg_port_dis = '0;
    cfg_irq_mask = 1'b1; stat_rd = 1'b0; phy_ok = 8'hff; rnd_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk(in_ready && !tx_valid && !tx_addr_valid, "R1 reset idle", int'({in_ready, tx_valid, tx_addr_valid}), 4);
    chk(port_status == 0 && !discard_flag && !irq, "R6 reset status", int'(port_status), 0);

    // Basic transfers, all ports answering
    push(3'd1, 8'h10, 1); push(3'd2, 8'h40, 1); push(3'd3, 8'hf0, 1);
    drain();
    chk(rx_n == exp_n, "R2 cells sent with clav", rx_n, exp_n);

    // Depth limits with a silent PHY and flush off
    phy_ok = 8'h00;
    cfg_depth = 4'd2;
    push(3'd0, 8'h00, 1); push(3'd0, 8'h33, 1);
    @(negedge clk);
    chk(!in_ready, "R1 full at depth 2", int'(in_ready), 0);
    cfg_depth = 4'd1;
    @(negedge clk);
    chk(!in_ready, "R1 full at depth 1", int'(in_ready), 0);
    cfg_depth = 4'd9;
    @(negedge clk);
    chk(in_ready, "R1 room at depth 9", int'(in_ready), 1);
    for (int k = 0; k < 7; k++) push(3'(k + 1), 8'(k * 17), 1);
    @(negedge clk);
    chk(!in_ready, "R1 full at depth 9", int'(in_ready), 0);
    cfg_depth = 4'd15;
    @(negedge clk);
    chk(!in_ready, "R1 depth above 9 acts as 9", int'(in_ready), 0);
    cfg_depth = 4'd9;
    repeat (300) @(negedge clk);
    chk(tx_addr_valid && tx_addr == 3'd0 && !tx_valid, "R4 head still waiting", int'(tx_addr_valid), 1);
    chk(port_status == 0, "R4 no discard without flush", int'(port_status), 0);
    chk(rx_n == 3, "R3 nothing passes blocked head", rx_n, 3);
    phy_ok = 8'hff;
    drain();
    chk(rx_n == exp_n, "R3 all queued cells delivered", rx_n, exp_n);

    // Timeout with threshold 5
    cfg_flush_en = 1'b1; cfg_thresh = 16'd5; phy_ok = 8'hef;
    push(3'd4, 8'h55, 0);
    count_wait(3'd4, n);
    chk(n == 6, "R5 wait cycles thresh 5", n, 6);
    chk(port_status == 8'h10 && discard_flag && irq, "R6 status bit 4 and irq", int'(port_status), 'h10);

    // Timeout with threshold 0
    cfg_thresh = 16'd0; phy_ok = 8'hbf;
    push(3'd6, 8'h66, 0);
    count_wait(3'd6, n);
    chk(n == 1, "R5 wait cycles thresh 0", n, 1);
    chk(port_status == 8'h50, "R6 status accumulates", int'(port_status), 'h50);

    // Port 4 still works after its timeout
    phy_ok = 8'hff;
    push(3'd4, 8'h77, 1);
    drain();
    chk(rx_n == exp_n, "R9 port 4 sends after timeout", rx_n, exp_n);

    // Read coinciding with a drop
    cfg_thresh = 16'd3; phy_ok = 8'hfb;
    push(3'd2, 8'h22, 0);
    repeat (3) @(negedge clk);
    chk(tx_addr_valid && tx_addr == 3'd2, "R5 head waiting before drop", int'(tx_addr_valid), 1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk(port_status == 8'h04 && discard_flag, "R7 same-edge drop kept", int'(port_status), 'h04);
    chk(!tx_addr_valid, "R5 dropped on thresh 3", int'(tx_addr_valid), 0);
    cfg_irq_mask = 1'b0;
    @(negedge clk);
    chk(!irq && discard_flag, "R6 irq masked", int'(irq), 0);
    cfg_irq_mask = 1'b1;
    @(negedge clk);
    chk(irq, "R6 irq unmasked", int'(irq), 1);
    pulse_read();
    chk(port_status == 0 && !discard_flag && !irq, "R7 read clears", int'(port_status), 0);

    // Disabled port
    cfg_port_dis = 8'h08; cfg_thresh = 16'd2; phy_ok = 8'hf7;
    push(3'd3, 8'h01, 0); push(3'd1, 8'h02, 1); push(3'd3, 8'h03, 0); push(3'd1, 8'h04, 1);
    drain();
    chk(rx_n == exp_n, "R8 other ports flow", rx_n, exp_n);
    chk(port_status == 0 && !irq, "R8 silent drops", int'(port_status), 0);
    cfg_port_dis = 8'h00; phy_ok = 8'hff;
    push(3'd3, 8'h05, 1);
    drain();
    chk(rx_n == exp_n, "R8 port 3 after re-enable", rx_n, exp_n);

    // Random traffic with toggling cell-available, flush off
    cfg_flush_en = 1'b0;
    cfg_depth = 4'(1 + ($urandom % 9));
    fork
      begin
        for (int k = 0; k < 40; k++) push(3'($urandom % 8), 8'($urandom), 1);
        rnd_done = 1'b1;
      end
      begin
        while (!rnd_done) begin
          @(negedge clk);
          phy_ok = 8'($urandom);
        end
      end
    join
    phy_ok = 8'hff;
    drain();
    chk(rx_n == exp_n, "R3 random traffic complete", rx_n, exp_n);
    chk(port_status == 0, "R4 random traffic no drops", int'(port_status), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule